// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides, for every received frame, whether its 48-bit destination address is wanted. It keeps a 64-bin table of single-bit flags. A group address is folded into a 6-bit bin number, and the frame is accepted when that bin is marked. Individual addresses never pass through the table.

Software programs the table one bin at a time. It writes a 32-bit control word that holds a bin number and a set/clear flag. To accept all group traffic, software marks every bin in turn. A separate promiscuous input overrides the filter and accepts everything. Each lookup is started by a valid strobe, and the decision comes out registered one clock later.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset all 64 bins are clear, so a group address is rejected when promiscuous mode is off.
- R2: A control write uses bits [5:0] as the bin number and bit 8 as the flag: flag 1 marks the bin, flag 0 clears it. All other bits of the word have no effect.
- R3: The bin number of an address is a 6-bit fold. The address is taken as a 48-bit value with its first octet in bits [47:40]. Hash bit (5-i) is the XOR of bits [8i+7:8i], for i from 0 to 5. So hash bit 0 is the parity of the first octet, and hash bit 5 is the parity of the last octet.
- R4: An address is a group address when bit 40 (bit 0 of the first octet) is 1. A group address is accepted exactly when its bin is marked.
- R5: An individual address (bit 40 equal to 0) is rejected, even when its bin is marked, unless promiscuous mode is on.
- R6: While promiscuous_en is 1, every lookup is accepted.
- R7: acc_valid is 1 exactly one clock after rx_valid was 1. acc_ok is 0 whenever acc_valid is 0.
- R8: A control write in the same cycle as a lookup does not affect that lookup. It only affects later lookups.
- R9: Marking all 64 bins accepts every group address. Clearing all 64 bins again rejects every group address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word: bin number [5:0], set flag [8] |
| promisc_en | input | 1 | Accept every frame |
| rx_valid | input | 1 | Lookup request strobe |
| rx_daddr | input | 48 | Destination address, first octet in [47:40] |
| acc_valid | output | 1 | Decision valid, one clock after rx_valid |
| acc_ok | output | 1 | Frame accepted |

## Verification
A bin that is set or cleared when it should not be shows up only at a lookup whose address folds to that bin. The lookup returns the wrong decision one clock after the strobe. The stimulus therefore sweeps addresses over many bins, and it programs patterns that differ in every hash bit position. A wrong fold order swaps bins, so it appears as soon as a single marked bin is probed next to its neighbours. A latency or same-cycle write fault shows up on the very next acc_valid pulse.

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
  parameter int ADDR_W   = 48,
  parameter int CTRL_W   = 32,
  parameter int EN_BIT   = 8,
  parameter int GROUP_BIT = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_wdata,
  input  logic              promisc_en,
  input  logic              rx_valid,
  input  logic [ADDR_W-1:0] rx_daddr,
  output logic              acc_valid,
  output logic              acc_ok
);
  localparam int NUM_OCT  = ADDR_W / 8;
  localparam int IDX_W    = NUM_OCT;
  localparam int NUM_BINS = 1 << IDX_W;

  logic [NUM_BINS-1:0] bin_q;
  logic [IDX_W-1:0]    hash;
  logic [IDX_W-1:0]    wr_idx;
  logic                is_group;
  logic                hit;

  for (genvar i = 0; i < NUM_OCT; i++) begin : g_fold
    assign hash[IDX_W-1-i] = ^rx_daddr[8*i +: 8];
  end

  assign wr_idx   = cfg_wdata[IDX_W-1:0];
  assign is_group = rx_daddr[GROUP_BIT];
  assign hit      = promisc_en | (is_group & bin_q[hash]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bin_q <= '0;
    end else if (cfg_we) begin
      bin_q[wr_idx] <= cfg_wdata[EN_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_valid <= 1'b0;
      acc_ok    <= 1'b0;
    end else begin
      acc_valid <= rx_valid;
      acc_ok    <= rx_valid & hit;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> acc_valid); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !acc_ok); // R7
  AST_PROMISC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && promisc_en) |=> acc_ok); // R6
  AST_UNICAST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !promisc_en && !rx_daddr[GROUP_BIT]) |=> !acc_ok); // R5
  AST_BIN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> bin_q[$past(wr_idx)] == $past(cfg_wdata[EN_BIT])); // R2
endmodule

// File: tb/sim_mcast_hash_filter.sv
module sim_mcast_hash_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        promisc_en = 1'b0;
  logic        rx_valid = 1'b0;
  logic [47:0] rx_daddr = '0;
  logic        acc_valid, acc_ok;

  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;
  logic [63:0] model = '0;

  always #10 clk = ~clk;

  mcast_hash_filter u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .promisc_en(promisc_en), .rx_valid(rx_valid), .rx_daddr(rx_daddr),
    .acc_valid(acc_valid), .acc_ok(acc_ok)
  );

  typedef struct packed {
    logic [47:0] addr;
    logic        prom;
    logic        exp;
  } vec_t;

  // bins marked when bin bit 0 is 0, i.e. first octet has even parity
  localparam vec_t VECS [12] = '{
    '{48'h03_00_00_00_00_00, 1'b0, 1'b1},
    '{48'h01_00_00_00_00_00, 1'b0, 1'b0},
    '{48'h07_12_34_56_78_9A, 1'b0, 1'b0},
    '{48'h0F_AB_CD_EF_01_23, 1'b0, 1'b1},
    '{48'h02_00_00_00_00_03, 1'b0, 1'b0},
    '{48'h00_FF_FF_FF_FF_FF, 1'b0, 1'b0},
    '{48'h01_00_5E_00_00_01, 1'b0, 1'b0},
    '{48'h33_33_00_00_00_01, 1'b0, 1'b1},
    '{48'h02_00_00_00_00_03, 1'b1, 1'b1},
    '{48'h01_00_5E_00_00_01, 1'b1, 1'b1},
    '{48'hFF_FF_FF_FF_FF_FF, 1'b0, 1'b1},
    '{48'h13_00_00_00_00_00, 1'b0, 1'b0}
  };

  function automatic logic [5:0] fold(input logic [47:0] a);
    logic [5:0] h;
    for (int i = 0; i < 6; i++) h[5-i] = ^a[8*i +: 8];
    return h;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic en, input logic [31:0] junk);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = (junk & ~32'h13F) | 32'(idx[5:0]) | (32'(en) << 8);
    @(negedge clk);
    cfg_we = 1'b0;
    model[idx[5:0]] = en;
  endtask

  task automatic look(input string req, input logic [47:0] a, input logic p,
                      input logic exp);
    @(negedge clk);
    rx_valid = 1'b1; rx_daddr = a; promisc_en = p;
    @(negedge clk);
    rx_valid = 1'b0; promisc_en = 1'b0;
    check({req, " valid"}, acc_valid, 1'b1);
    check(req, acc_ok, exp);
  endtask

  task automatic fill(input logic en);
    for (int k = 0; k < 64; k++) wr(k, en, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 reset valid", acc_valid, 1'b0);
    look("R1", 48'h03_00_00_00_00_00, 1'b0, 1'b0);
    look("R1", 48'hFF_FF_FF_FF_FF_FF, 1'b0, 1'b0);

    // R2: junk in unused bits
    for (int k = 0; k < 64; k++) wr(k, (k % 2) == 0, 32'hA5A5A0C0);
    foreach (VECS[n])
      look(VECS[n].prom ? "R6" : "R4", VECS[n].addr, VECS[n].prom, VECS[n].exp);

    // R3: single bin 0x20 probes fold order
    fill(1'b0);
    wr(6'h20, 1'b1, 32'hFFFF_FE00);
    look("R3", 48'h03_00_00_00_00_01, 1'b0, 1'b1);
    look("R3", 48'h03_00_00_00_01_00, 1'b0, 1'b0);
    look("R3", 48'h01_00_00_00_00_01, 1'b0, 1'b0);
    // R5: unicast folding to marked bin
    look("R5", 48'h00_00_00_00_00_01, 1'b0, 1'b0);
    // R2: clear flag removes the bin
    wr(6'h20, 1'b0, 32'h0);
    look("R2", 48'h03_00_00_00_00_01, 1'b0, 1'b0);

    // R8: same-cycle write
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 32'h0000_0120;
    rx_valid = 1'b1; rx_daddr = 48'h03_00_00_00_00_01;
    @(negedge clk);
    cfg_we = 1'b0; rx_valid = 1'b0;
    model[6'h20] = 1'b1;
    check("R8 same cycle", acc_ok, 1'b0);
    check("R7 idle", acc_ok, 1'b0);
    @(negedge clk);
    check("R7 idle valid", acc_valid, 1'b0);
    look("R8 next", 48'h03_00_00_00_00_01, 1'b0, 1'b1);

    // random bins and addresses against the fold model
    fill(1'b0);
    for (int k = 0; k < 64; k++) if ($urandom_range(1, 0) == 1) wr(k, 1'b1, $urandom);
    for (int t = 0; t < 300; t++) begin
      logic [47:0] a;
      a = {$urandom, $urandom};
      look("R4 rand", a, 1'b0, a[40] & model[fold(a)]);
    end

    // R9
    fill(1'b1);
    for (int t = 0; t < 40; t++) begin
      logic [47:0] a;
      a = {$urandom, $urandom};
      look("R9 all", a, 1'b0, a[40]);
    end
    fill(1'b0);
    for (int t = 0; t < 40; t++) begin
      logic [47:0] a;
      a = {$urandom, $urandom} | 48'h01_00_00_00_00_00;
      look("R9 none", a, 1'b0, 1'b0);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule